// File: doc/BRIEF.md
# Dual-Mode Converter Input Front End

This block is the digital front end of a two-channel, 14-bit digital-to-analog converter. It takes the converter's data buses and its strobe pins. It keeps one input (holding) register and one output register per channel. The two output codes, one per channel, drive the converter cores. All pins are sampled on one fast system clock. A strobe acts on the system clock edge where it is first seen high after having been seen low.

A mode input gives the four strobe pins one of two sets of roles. In dual mode, each channel has its own bus, write strobe and update strobe, so the two channels run independently. In interleaved mode, a single bus carries alternating I and Q words. The channel A write strobe captures each word. The channel B write pin acts as a select line that steers the word to channel A or channel B. The channel A update pin acts as a shared update clock, which is divided by two internally. The channel B update pin acts as a reset that gates that divider. A power-down input freezes the whole front end.

Top module: `dual_dac_frontend`

## Requirements
- R1: After reset, both holding registers, both output codes and the divider phase are zero. Update strobes with no prior write leave the outputs at zero.
- R2: The mode input set to 1 selects dual mode and set to 0 selects interleaved mode. In interleaved mode, `wr_a_i` is the shared write, `upd_a_i` the shared update clock, `upd_b_i` the divider reset and `wr_b_i` the select.
- R3: In dual mode, a rising edge on a channel's write pin (seen low in one sample, high in the next) captures that channel's bus into its holding register. A strobe held high captures only once. A captured word does not reach the output by itself.
- R4: In dual mode, a rising edge on a channel's update pin copies that channel's holding register to its output. When a write edge and an update edge fall in the same sample, the output takes the word held before that write.
- R5: In interleaved mode, a write edge captures `data_a_i` into holding register B when the select is 1 and into holding register A when it is 0. `data_b_i` is ignored.
- R6: In interleaved mode, both outputs load their holding registers together on every second rising edge of the shared update clock.
- R7: While the interleave reset is high, the divider phase is forced to zero and shared clock edges are ignored. After release, the first load comes on the second rising edge of the shared clock.
- R8: While power-down is high, the outputs and holding registers keep their values, all strobe edges are ignored and the divider phase is held. A strobe that rises during power-down does not act when power-down is released.
- R9: Codes are straight binary, bit 13 the MSB and bit 0 the LSB, and pass through unchanged, including all-ones and MSB-only.
- R10: In dual mode, the divider phase is kept at zero, so on entering interleaved mode the first load comes on the second shared clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dual_i | input | 1 | 1 = dual mode, 0 = interleaved mode |
| pwr_down_i | input | 1 | Freezes all state while high |
| wr_a_i | input | 1 | Write strobe for channel A; shared write in interleaved mode |
| upd_a_i | input | 1 | Update strobe for channel A; shared update clock in interleaved mode |
| upd_b_i | input | 1 | Update strobe for channel B; divider reset in interleaved mode |
| wr_b_i | input | 1 | Write strobe for channel B; select (1 = B) in interleaved mode |
| data_a_i | input | 14 | Channel A bus; the only bus used in interleaved mode |
| data_b_i | input | 14 | Channel B bus, used in dual mode only |
| code_a_o | output | 14 | Registered channel A code |
| code_b_o | output | 14 | Registered channel B code |

## Verification
The assertions assume that every strobe is a level held for at least one sample of the system clock. They also assume that in interleaved mode the select changes only while the shared write strobe is low, and that the mode changes only while all strobes are low. The stimulus changes the select only in cycles where it also drives the shared write and the shared update clock low. A bench monitor flags any select change it sees while the write strobe is high. Mode switches are surrounded by idle cycles with every strobe low.

// File: rtl/dual_dac_frontend_pkg.sv
package dual_dac_frontend_pkg;

    // Index of each strobe pin inside the sampled strobe vector.
    typedef enum int unsigned {
        PIN_WR_A  = 0,
        PIN_UPD_A = 1,
        PIN_UPD_B = 2,
        PIN_WR_B  = 3
    } pin_idx_e;

    localparam int unsigned NUM_STROBES = 4;

    typedef enum logic {
        MODE_INTERLEAVED = 1'b0,
        MODE_DUAL        = 1'b1
    } port_mode_e;

endpackage

// File: rtl/dual_dac_frontend_edge.sv
module dual_dac_frontend_edge #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] rise_o
);

    typedef struct packed {
        logic [N-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    // History is tracked at all times, including power-down.
    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise_o[i] = pin_i[i] & ~st_q.prev[i];

        AST_NO_BACK_TO_BACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[i] |=> !rise_o[i]); // R3
    end

endmodule

// File: rtl/dual_dac_frontend_capture.sv
module dual_dac_frontend_capture
    import dual_dac_frontend_pkg::*;
#(
    parameter int unsigned DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              pd_i,
    input  logic              wr_a_rise_i,
    input  logic              wr_b_rise_i,
    input  logic              sel_i,
    input  logic [DATA_W-1:0] data_a_i,
    input  logic [DATA_W-1:0] data_b_i,
    output logic [DATA_W-1:0] hold_a_o,
    output logic [DATA_W-1:0] hold_b_o
);

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pd_i) begin
            if (port_mode_e'(mode_i) == MODE_DUAL) begin
                if (wr_a_rise_i) st_d.a = data_a_i;
                if (wr_b_rise_i) st_d.b = data_b_i;
            end else if (wr_a_rise_i) begin
                if (sel_i) begin
                    st_d.b = data_a_i;
                end else begin
                    st_d.a = data_a_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_a_o = st_q.a;
    assign hold_b_o = st_q.b;

    AST_DUAL_A_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && !wr_a_rise_i) |=> $stable(hold_a_o)); // R3

    AST_IL_SEL_LOW_SPARES_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && !sel_i) |=> $stable(hold_b_o)); // R5

    AST_IL_SEL_HIGH_SPARES_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && sel_i) |=> $stable(hold_a_o)); // R5

    AST_PD_HOLDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        pd_i |=> ($stable(hold_a_o) && $stable(hold_b_o))); // R8

endmodule

// File: rtl/dual_dac_frontend_update.sv
module dual_dac_frontend_update
    import dual_dac_frontend_pkg::*;
#(
    parameter int unsigned DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              pd_i,
    input  logic              upd_a_rise_i,
    input  logic              upd_b_rise_i,
    input  logic              iq_rst_i,
    input  logic [DATA_W-1:0] hold_a_i,
    input  logic [DATA_W-1:0] hold_b_i,
    output logic [DATA_W-1:0] code_a_o,
    output logic [DATA_W-1:0] code_b_o
);

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic              phase;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pd_i) begin
            if (port_mode_e'(mode_i) == MODE_DUAL) begin
                st_d.phase = 1'b0;
                if (upd_a_rise_i) st_d.a = hold_a_i;
                if (upd_b_rise_i) st_d.b = hold_b_i;
            end else if (iq_rst_i) begin
                st_d.phase = 1'b0;
            end else if (upd_a_rise_i) begin
                if (st_q.phase) begin
                    st_d.a     = hold_a_i;
                    st_d.b     = hold_b_i;
                    st_d.phase = 1'b0;
                end else begin
                    st_d.phase = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_a_o = st_q.a;
    assign code_b_o = st_q.b;

    AST_DUAL_B_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && !upd_b_rise_i) |=> $stable(code_b_o)); // R4

    AST_IL_RESET_CLEARS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && !pd_i && iq_rst_i) |=> !st_q.phase); // R7

    AST_IL_RESET_FREEZES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && iq_rst_i) |=> ($stable(code_a_o) && $stable(code_b_o))); // R7

    AST_IL_FIRST_EDGE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && !st_q.phase) |=> ($stable(code_a_o) && $stable(code_b_o))); // R6

    AST_DUAL_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && !pd_i) |=> !st_q.phase); // R10

    AST_PD_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        pd_i |=> ($stable(code_a_o) && $stable(code_b_o) && $stable(st_q.phase))); // R8

endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
    import dual_dac_frontend_pkg::*;
#(
    parameter int unsigned DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_dual_i,
    input  logic              pwr_down_i,
    input  logic              wr_a_i,
    input  logic              upd_a_i,
    input  logic              upd_b_i,
    input  logic              wr_b_i,
    input  logic [DATA_W-1:0] data_a_i,
    input  logic [DATA_W-1:0] data_b_i,
    output logic [DATA_W-1:0] code_a_o,
    output logic [DATA_W-1:0] code_b_o
);

    logic [NUM_STROBES-1:0] strobe_pins;
    logic [NUM_STROBES-1:0] strobe_rise;
    logic [DATA_W-1:0]      hold_a;
    logic [DATA_W-1:0]      hold_b;

    always_comb begin
        strobe_pins            = '0;
        strobe_pins[PIN_WR_A]  = wr_a_i;
        strobe_pins[PIN_UPD_A] = upd_a_i;
        strobe_pins[PIN_UPD_B] = upd_b_i;
        strobe_pins[PIN_WR_B]  = wr_b_i;
    end

    dual_dac_frontend_edge #(
        .N (NUM_STROBES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (strobe_pins),
        .rise_o (strobe_rise)
    );

    // In interleaved mode the channel B write pin is a level select.
    dual_dac_frontend_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_dual_i),
        .pd_i        (pwr_down_i),
        .wr_a_rise_i (strobe_rise[PIN_WR_A]),
        .wr_b_rise_i (strobe_rise[PIN_WR_B]),
        .sel_i       (wr_b_i),
        .data_a_i    (data_a_i),
        .data_b_i    (data_b_i),
        .hold_a_o    (hold_a),
        .hold_b_o    (hold_b)
    );

    // In interleaved mode the channel B update pin is a level reset.
    dual_dac_frontend_update #(
        .DATA_W (DATA_W)
    ) u_update (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_dual_i),
        .pd_i         (pwr_down_i),
        .upd_a_rise_i (strobe_rise[PIN_UPD_A]),
        .upd_b_rise_i (strobe_rise[PIN_UPD_B]),
        .iq_rst_i     (upd_b_i),
        .hold_a_i     (hold_a),
        .hold_b_i     (hold_b),
        .code_a_o     (code_a_o),
        .code_b_o     (code_b_o)
    );

    AST_DUAL_A_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dual_i && !(upd_a_i && !$past(upd_a_i))) |=> $stable(code_a_o)); // R4

endmodule

// File: tb/dual_dac_frontend_bench.sv
module dual_dac_frontend_bench;

    localparam int W = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode = 1'b1;
    logic         pd = 1'b0;
    logic         wr_a = 1'b0, upd_a = 1'b0, upd_b = 1'b0, wr_b = 1'b0;
    logic [W-1:0] data_a = '0, data_b = '0;
    logic [W-1:0] code_a, code_b;

    int    checks = 0;
    int    failures = 0;
    bit    finished = 1'b0;
    string cur_tag = "R1";

    always #4 clk = ~clk;   // 125 MHz

    dual_dac_frontend u_dual_dac_frontend (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_dual_i (mode),
        .pwr_down_i  (pd),
        .wr_a_i      (wr_a),
        .upd_a_i     (upd_a),
        .upd_b_i     (upd_b),
        .wr_b_i      (wr_b),
        .data_a_i    (data_a),
        .data_b_i    (data_b),
        .code_a_o    (code_a),
        .code_b_o    (code_b)
    );

    // ---------------- behavioural reference model ----------------
    logic [W-1:0] m_ha, m_hb, m_a, m_b;
    logic         m_ph;
    logic         p_wa, p_ua, p_ub, p_wb;
    logic         sel_seen;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ha <= '0; m_hb <= '0; m_a <= '0; m_b <= '0; m_ph <= 1'b0;
            p_wa <= 1'b0; p_ua <= 1'b0; p_ub <= 1'b0; p_wb <= 1'b0;
        end else begin
            p_wa <= wr_a; p_ua <= upd_a; p_ub <= upd_b; p_wb <= wr_b;
            if (!pd) begin
                if (mode) begin
                    if (wr_a && !p_wa)  m_ha <= data_a;
                    if (wr_b && !p_wb)  m_hb <= data_b;
                    if (upd_a && !p_ua) m_a  <= m_ha;
                    if (upd_b && !p_ub) m_b  <= m_hb;
                    m_ph <= 1'b0;
                end else begin
                    if (wr_a && !p_wa) begin
                        if (wr_b) m_hb <= data_a;
                        else      m_ha <= data_a;
                    end
                    if (upd_b) begin
                        m_ph <= 1'b0;
                    end else if (upd_a && !p_ua) begin
                        if (m_ph) begin
                            m_a <= m_ha; m_b <= m_hb; m_ph <= 1'b0;
                        end else begin
                            m_ph <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // Model comparison on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check({cur_tag, " model A"}, code_a, m_a);
            check({cur_tag, " model B"}, code_b, m_b);
        end
    end

    // Select must not move while the shared write strobe is high (R5).
    always @(posedge clk) begin
        if (rst_n && !mode && wr_a && !finished) begin
            checks++;
            if (wr_b !== sel_seen) begin
                failures++;
                $display("FAIL R5 select moved under write got=%b expected=%b", wr_b, sel_seen);
            end
        end
        sel_seen <= wr_b;
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_wr_a(); wr_a = 1'b1; tick(); wr_a = 1'b0; tick(); endtask
    task automatic pulse_wr_b(); wr_b = 1'b1; tick(); wr_b = 1'b0; tick(); endtask
    task automatic pulse_upd_a(); upd_a = 1'b1; tick(); upd_a = 1'b0; tick(); endtask
    task automatic pulse_upd_b(); upd_b = 1'b1; tick(); upd_b = 1'b0; tick(); endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired got=running expected=done");
        finish_run();
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick();

        // R1: reset state, update strobes with nothing written
        cur_tag = "R1";
        check("R1 reset A", code_a, 14'h0000);
        check("R1 reset B", code_b, 14'h0000);
        pulse_upd_a(); pulse_upd_b();
        check("R1 empty update A", code_a, 14'h0000);
        check("R1 empty update B", code_b, 14'h0000);

        // R3, R4: dual mode capture then update
        cur_tag = "R3";
        data_a = 14'h1234; pulse_wr_a();
        data_b = 14'h0ABC; pulse_wr_b();
        check("R3 write alone A", code_a, 14'h0000);
        check("R3 write alone B", code_b, 14'h0000);
        cur_tag = "R4";
        pulse_upd_a();
        check("R4 update A", code_a, 14'h1234);
        check("R4 B untouched", code_b, 14'h0000);
        pulse_upd_b();
        check("R4 update B", code_b, 14'h0ABC);

        // R4: write and update in the same sample
        data_a = 14'h3FFF; wr_a = 1'b1; upd_a = 1'b1; tick();
        wr_a = 1'b0; upd_a = 1'b0; tick();
        check("R4 same-sample old word", code_a, 14'h1234);
        cur_tag = "R9";
        pulse_upd_a();
        check("R9 all ones", code_a, 14'h3FFF);

        // R3: held strobe captures once; R9 MSB only
        cur_tag = "R3";
        data_a = 14'h2000; wr_a = 1'b1; tick();
        data_a = 14'h0001; tick(2);
        wr_a = 1'b0; tick();
        pulse_upd_a();
        check("R3 held strobe single capture (R9 MSB)", code_a, 14'h2000);

        // R2, R5, R6: interleaved mode
        cur_tag = "R2";
        mode = 1'b0; tick();
        upd_b = 1'b1; tick(); upd_b = 1'b0; tick();
        cur_tag = "R5";
        data_a = 14'h0111; wr_b = 1'b0; pulse_wr_a();
        wr_b = 1'b1; tick();
        data_a = 14'h0222; data_b = 14'h3333; pulse_wr_a();
        wr_b = 1'b0; tick();
        cur_tag = "R6";
        pulse_upd_a();
        check("R6 first edge no load A", code_a, 14'h2000);
        check("R6 first edge no load B", code_b, 14'h0ABC);
        pulse_upd_a();
        check("R6 second edge A (R5 select 0)", code_a, 14'h0111);
        check("R5 select 1 to B, data_b ignored", code_b, 14'h0222);

        // R7: reset gates the shared clock
        cur_tag = "R7";
        data_a = 14'h0AAA; pulse_wr_a();
        upd_b = 1'b1; tick();
        pulse_upd_a(); pulse_upd_a(); pulse_upd_a();
        check("R7 gated clock", code_a, 14'h0111);
        upd_b = 1'b0; tick();
        pulse_upd_a();
        check("R7 first after release", code_a, 14'h0111);
        pulse_upd_a();
        check("R7 second after release", code_a, 14'h0AAA);
        data_a = 14'h0555; pulse_wr_a();
        pulse_upd_a();
        pulse_upd_b();
        pulse_upd_a();
        check("R7 mid-phase reset", code_a, 14'h0AAA);
        pulse_upd_a();
        check("R7 load after mid-phase reset", code_a, 14'h0555);

        // R8: power-down
        cur_tag = "R8";
        data_a = 14'h0777; pulse_wr_a();
        pulse_upd_a();
        pd = 1'b1; tick();
        data_a = 14'h1111; pulse_wr_a();
        pulse_upd_a(); pulse_upd_a();
        check("R8 held under power-down", code_a, 14'h0555);
        data_a = 14'h2222; wr_a = 1'b1; tick();
        pd = 1'b0; tick();
        wr_a = 1'b0; tick();
        pulse_upd_a();
        check("R8 phase kept, writes ignored", code_a, 14'h0777);

        // R10: dual mode clears the phase
        cur_tag = "R10";
        pulse_upd_a();
        mode = 1'b1; tick();
        mode = 1'b0; tick();
        data_a = 14'h0123; pulse_wr_a();
        pulse_upd_a();
        check("R10 no load on first edge", code_a, 14'h0777);
        pulse_upd_a();
        check("R10 load on second edge", code_a, 14'h0123);

        // Random dual-mode traffic (R3, R4, R8)
        cur_tag = "R4";
        mode = 1'b1; tick(2);
        for (int c = 0; c < 3000; c++) begin
            wr_a   = ($urandom % 3) == 0;
            wr_b   = ($urandom % 3) == 0;
            upd_a  = ($urandom % 2) == 0;
            upd_b  = ($urandom % 2) == 0;
            pd     = ($urandom % 32) == 0;
            data_a = W'($urandom);
            data_b = W'($urandom);
            tick();
        end
        wr_a = 1'b0; wr_b = 1'b0; upd_a = 1'b0; upd_b = 1'b0; pd = 1'b0;
        tick(3);

        // Random interleaved traffic (R5, R6, R7, R8)
        cur_tag = "R6";
        mode = 1'b0; tick(3);
        for (int c = 0; c < 3000; c++) begin
            wr_a   = ($urandom % 3) == 0;
            upd_a  = ($urandom % 2) == 0;
            upd_b  = ($urandom % 16) == 0;
            pd     = ($urandom % 32) == 0;
            data_a = W'($urandom);
            data_b = W'($urandom);
            if (($urandom % 4) == 0) begin
                wr_a  = 1'b0;
                upd_a = 1'b0;
                wr_b  = ~wr_b;
            end
            tick();
        end
        wr_a = 1'b0; upd_a = 1'b0; upd_b = 1'b0; pd = 1'b0;
        tick(3);

        finish_run();
    end

endmodule